// File: doc/BRIEF.md
# Low-Confidence Branch Fetch Throttle

This block decides when instruction fetch should pause because too many speculative branches of doubtful prediction quality are still in flight. Each fetched branch is given a confidence class when it enters the pipeline. The class comes from a table of per-address run counters. A counter counts how many times in a row its branch was predicted correctly, and a misprediction clears it. Optionally, a short window after any resolved misprediction forces the next few fetched branches into the low class, whatever their counters say.

The class of each fetched branch is kept in an in-order tag queue. When the oldest branch resolves, its tag is popped. A running total of unresolved low-class branches goes up when such a branch is fetched and down when one resolves. The fetch-gate output is high while that total has reached the threshold supplied on an input (normally 2). It drops as soon as enough low-class branches resolve. A flush empties the queue and zeroes the total in one cycle.

Top module: `fetch_gate_ctrl`

## Requirements
- R1: After reset the low-confidence count is 0 and the gate is low. Every table counter starts at 0, so every branch starts in the low class.
- R2: A branch is classed high only when its counter is at least CONF_N. A correct resolve adds one to its counter. A mispredicted resolve clears its counter, so the run must start again from zero.
- R3: A fetched branch classed low raises the count by one in the next cycle. A fetched branch classed high leaves the count unchanged.
- R4: Tags pop in fetch order, one per resolve. A resolve whose popped tag is low lowers the count by one. A resolve whose popped tag is high leaves the count unchanged.
- R5: fetch_gate is 1 exactly when gate_thresh is not 0 and the count is greater than or equal to gate_thresh. A threshold of 0 keeps the gate low.
- R6: With dist_mode set, the DIST_N branches fetched after a mispredicted resolve are classed low, even when their counters are high. With dist_mode clear, this window has no effect.
- R7: A fetch and a resolve in the same cycle are both applied to the queue and to the count.
- R8: A resolve that finds the tag queue empty leaves the count unchanged, and the count never goes below 0. The resolve still trains the table.
- R9: A fetch that arrives while the queue holds FIFO_DEPTH tags, with no resolve in the same cycle, is not tracked and leaves the count unchanged.
- R10: A flush sets the count to 0 and the gate low in the next cycle, and empties the queue. A fetch or resolve in the flush cycle is not tracked.
- R11: Counters saturate at their maximum value. Further correct resolves keep a saturated branch high and never wrap it back to 0.
- R12: The table index is the low IDX_W bits of the PC (pc[IDX_W-1:0]). Two PCs that differ only above those bits share one counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Drops all tracked branches |
| dist_mode | input | 1 | Enables post-misprediction low-class window |
| gate_thresh | input | CNT_W | Count at which fetch is gated; 0 disables |
| fetch_vld | input | 1 | A branch is fetched this cycle |
| fetch_pc | input | PC_W | Address of the fetched branch |
| resolve_vld | input | 1 | The oldest branch resolves this cycle |
| resolve_pc | input | PC_W | Address of the resolving branch |
| resolve_miss | input | 1 | The resolving branch was mispredicted |
| fetch_gate | output | 1 | Stall request to fetch |
| lowconf_cnt | output | CNT_W | Unresolved low-class branches |

## Verification
The bench builds the block with a 16-entry table (IDX_W=4), 4-bit counters, CONF_N=3, a distance window of 4 and a tag queue only 4 deep. The shallow queue makes the full-queue drop and the empty-queue resolve reachable in a few cycles. The small table lets two nearby addresses alias onto one counter. With CONF_N=3, runs can be trained, broken and retrained quickly. Exactly 16 correct resolves are applied to one counter, which separates saturation from a wrap back to zero.

// File: rtl/fgc_pkg.sv
`timescale 1ns/1ps
package fgc_pkg;
  // Confidence class attached to each in-flight branch
  typedef enum logic {
    TAG_HIGH = 1'b0,
    TAG_LOW  = 1'b1
  } conf_tag_e;
endpackage

// File: rtl/fgc_conf_table.sv
`timescale 1ns/1ps
module fgc_conf_table #(
  parameter int IDX_W  = 6,
  parameter int CONF_W = 4,
  parameter int CONF_N = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_low,
  input  logic             upd_vld,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             upd_miss
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam logic [CONF_W-1:0] CMAX  = '1;
  localparam logic [CONF_W-1:0] HI_AT = CONF_W'(CONF_N);

  logic [CONF_W-1:0] ctr_q [ENTRIES];
  logic [CONF_W-1:0] ctr_d [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    always_comb begin
      ctr_d[e] = ctr_q[e];
      if (upd_vld && (upd_idx == IDX_W'(e))) begin
        if (upd_miss)             ctr_d[e] = '0;
        else if (ctr_q[e] != CMAX) ctr_d[e] = ctr_q[e] + 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctr_q[e] <= '0;
      else        ctr_q[e] <= ctr_d[e];
    end
  end

  assign rd_low = (ctr_q[rd_idx] < HI_AT);

  // R2: a misprediction restarts the run from zero
  assert_miss_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_vld && upd_miss) |=> (ctr_q[$past(upd_idx)] == '0));

  // R11: saturated counter holds under further correct resolves
  assert_sat_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_vld && !upd_miss && (ctr_q[upd_idx] == CMAX)) |=> (ctr_q[$past(upd_idx)] == CMAX));
endmodule

// File: rtl/fgc_tag_fifo.sv
`timescale 1ns/1ps
module fgc_tag_fifo
  import fgc_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      flush,
  input  logic      push,
  input  conf_tag_e push_tag,
  input  logic      pop,
  output logic      push_ok,
  output logic      pop_ok,
  output conf_tag_e pop_tag
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int OCC_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [OCC_W-1:0] FULL = OCC_W'(DEPTH);

  conf_tag_e        mem_q [DEPTH];
  conf_tag_e        mem_d [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [OCC_W-1:0] occ_q, occ_d;

  assign pop_ok  = pop && (occ_q != '0) && !flush;
  assign push_ok = push && !flush && ((occ_q != FULL) || pop_ok);
  assign pop_tag = mem_q[rd_q];

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    occ_d = occ_q;
    if (flush) begin
      wr_d  = '0;
      rd_d  = '0;
      occ_d = '0;
    end else begin
      if (push_ok) wr_d = (wr_q == LAST) ? '0 : wr_q + 1'b1;
      if (pop_ok)  rd_d = (rd_q == LAST) ? '0 : rd_q + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   occ_d = occ_q + 1'b1;
        2'b01:   occ_d = occ_q - 1'b1;
        default: occ_d = occ_q;
      endcase
    end
  end

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    always_comb begin
      mem_d[s] = mem_q[s];
      if (push_ok && (wr_q == PTR_W'(s))) mem_d[s] = push_tag;
    end
    always_ff @(posedge clk) begin
      mem_q[s] <= mem_d[s];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      occ_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      occ_q <= occ_d;
    end
  end

  // R9: a push into a full queue without a pop is dropped
  assert_full_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((occ_q == FULL) && push && !pop && !flush) |=> (occ_q == FULL));

  // R10: flush empties the queue
  assert_flush_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (occ_q == '0));
endmodule

// File: rtl/fgc_lowconf_counter.sv
`timescale 1ns/1ps
module fgc_lowconf_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             inc,
  input  logic             dec,
  input  logic [CNT_W-1:0] thresh,
  output logic [CNT_W-1:0] cnt,
  output logic             gate
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (flush) begin
      cnt_d = '0;
    end else begin
      case ({inc, dec})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = (cnt_q != '0) ? cnt_q - 1'b1 : cnt_q;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt  = cnt_q;
  assign gate = (thresh != '0) && (cnt_q >= thresh);

  // R3: a low-class fetch raises the count by one
  assert_inc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !dec && !flush) |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R4: a low-tag resolve lowers the count by one
  assert_dec_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !inc && !flush && (cnt_q != '0)) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R7: simultaneous fetch and resolve cancel out
  assert_both_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && dec && !flush) |=> $stable(cnt_q));

  // R8: no underflow below zero
  assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt_q == '0) && !inc) |=> (cnt_q == '0));

  // R10: flush zeroes the count
  assert_flush_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (cnt_q == '0));
endmodule

// File: rtl/fetch_gate_ctrl.sv
`timescale 1ns/1ps
module fetch_gate_ctrl
  import fgc_pkg::*;
#(
  parameter int PC_W       = 32,
  parameter int IDX_W      = 6,
  parameter int CONF_W     = 4,
  parameter int CONF_N     = 4,
  parameter int DIST_N     = 4,
  parameter int FIFO_DEPTH = 8,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             dist_mode,
  input  logic [CNT_W-1:0] gate_thresh,
  input  logic             fetch_vld,
  input  logic [PC_W-1:0]  fetch_pc,
  input  logic             resolve_vld,
  input  logic [PC_W-1:0]  resolve_pc,
  input  logic             resolve_miss,
  output logic             fetch_gate,
  output logic [CNT_W-1:0] lowconf_cnt
);
  localparam int DIST_W = $clog2(DIST_N + 1);
  localparam logic [DIST_W-1:0] DIST_LOAD = DIST_W'(DIST_N);

  logic              tbl_low;
  logic              fetch_low;
  logic [DIST_W-1:0] dist_q, dist_d;
  logic              push_ok, pop_ok;
  conf_tag_e         pop_tag;
  conf_tag_e         push_tag;
  logic              cnt_inc, cnt_dec;

  fgc_conf_table #(
    .IDX_W (IDX_W),
    .CONF_W(CONF_W),
    .CONF_N(CONF_N)
  ) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_idx  (fetch_pc[IDX_W-1:0]),
    .rd_low  (tbl_low),
    .upd_vld (resolve_vld),
    .upd_idx (resolve_pc[IDX_W-1:0]),
    .upd_miss(resolve_miss)
  );

  // Distance window: counts fetched branches left after a misprediction
  always_comb begin
    dist_d = dist_q;
    if (resolve_vld && resolve_miss)     dist_d = DIST_LOAD;
    else if (fetch_vld && dist_q != '0)  dist_d = dist_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dist_q <= '0;
    else        dist_q <= dist_d;
  end

  assign fetch_low = tbl_low || (dist_mode && (dist_q != '0));
  assign push_tag  = fetch_low ? TAG_LOW : TAG_HIGH;

  fgc_tag_fifo #(
    .DEPTH(FIFO_DEPTH)
  ) u_tags (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (flush),
    .push    (fetch_vld),
    .push_tag(push_tag),
    .pop     (resolve_vld),
    .push_ok (push_ok),
    .pop_ok  (pop_ok),
    .pop_tag (pop_tag)
  );

  assign cnt_inc = push_ok && fetch_low;
  assign cnt_dec = pop_ok && (pop_tag == TAG_LOW);

  fgc_lowconf_counter #(
    .CNT_W(CNT_W)
  ) u_count (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (flush),
    .inc   (cnt_inc),
    .dec   (cnt_dec),
    .thresh(gate_thresh),
    .cnt   (lowconf_cnt),
    .gate  (fetch_gate)
  );

  // R6: a resolved misprediction opens a full window
  assert_dist_arm_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (resolve_vld && resolve_miss) |=> (dist_q == DIST_LOAD));

  // R6: the window closes one fetch at a time
  assert_dist_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_vld && !(resolve_vld && resolve_miss) && (dist_q != '0))
      |=> (dist_q == $past(dist_q) - 1'b1));

  // R5: the gate never rises while the count is zero
  assert_gate_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lowconf_cnt == '0) |-> !fetch_gate);
endmodule

// File: tb/tb_fetch_gate_ctrl.sv
`timescale 1ns/1ps
module tb_fetch_gate_ctrl;
  localparam int PC_W  = 16;
  localparam int DEPTH = 4;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             clk = 1'b0;
  logic             rst_n;
  logic             flush, dist_mode;
  logic [CNT_W-1:0] gate_thresh;
  logic             fetch_vld, resolve_vld, resolve_miss;
  logic [PC_W-1:0]  fetch_pc, resolve_pc;
  logic             fetch_gate;
  logic [CNT_W-1:0] lowconf_cnt;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  fetch_gate_ctrl #(
    .PC_W(PC_W), .IDX_W(4), .CONF_W(4), .CONF_N(3), .DIST_N(4), .FIFO_DEPTH(DEPTH)
  ) dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .dist_mode(dist_mode),
    .gate_thresh(gate_thresh), .fetch_vld(fetch_vld), .fetch_pc(fetch_pc),
    .resolve_vld(resolve_vld), .resolve_pc(resolve_pc), .resolve_miss(resolve_miss),
    .fetch_gate(fetch_gate), .lowconf_cnt(lowconf_cnt)
  );

  task automatic check(input int act, input int exp, input string what);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic chk(input int exp_cnt, input int exp_gate, input string req);
    check(int'(lowconf_cnt), exp_cnt, {req, " count"});
    check(int'(fetch_gate), exp_gate, {req, " gate"});
  endtask

  // One clock with the given stimulus; returns 1 ns after the edge
  task automatic step(input logic fv, input int fpc, input logic rv, input int rpc,
                      input logic rm, input logic fl);
    fetch_vld = fv; fetch_pc = PC_W'(fpc);
    resolve_vld = rv; resolve_pc = PC_W'(rpc); resolve_miss = rm;
    flush = fl;
    @(posedge clk); #1;
    fetch_vld = 1'b0; resolve_vld = 1'b0; resolve_miss = 1'b0; flush = 1'b0;
  endtask

  task automatic fetch(input int pc);   step(1'b1, pc, 1'b0, 0, 1'b0, 1'b0); endtask
  task automatic res_ok(input int pc);  step(1'b0, 0, 1'b1, pc, 1'b0, 1'b0); endtask
  task automatic res_bad(input int pc); step(1'b0, 0, 1'b1, pc, 1'b1, 1'b0); endtask
  task automatic do_flush();            step(1'b0, 0, 1'b0, 0, 1'b0, 1'b1); endtask

  task automatic t_reset();
    chk(0, 0, "R1 reset");
  endtask

  task automatic t_count_gate();
    do_flush();
    fetch(1);  chk(1, 0, "R3 first low fetch");
    fetch(2);  chk(2, 1, "R5 gate at threshold 2");
    res_ok(1); chk(1, 0, "R4 low resolve");
    res_ok(2); chk(0, 0, "R4 second low resolve");
  endtask

  task automatic t_training();
    do_flush();
    for (int i = 0; i < 3; i++) res_ok(5);
    chk(0, 0, "R8 resolves on empty queue");
    fetch(5);   chk(0, 0, "R2 trained branch is high");
    res_bad(5); chk(0, 0, "R4 high tag resolve");
    res_ok(5); res_ok(5);
    fetch(5);   chk(1, 0, "R2 run restarted after miss");
    fetch(5);   chk(2, 1, "R2 still low, gate on");
    do_flush(); chk(0, 0, "R10 flush clears");
  endtask

  task automatic t_alias();
    do_flush();
    for (int i = 0; i < 3; i++) res_ok(7);
    fetch(7 + 16); chk(0, 0, "R12 aliased pc shares counter");
    fetch(8);      chk(1, 0, "R12 other index still low");
    do_flush();
  endtask

  task automatic t_distance();
    do_flush();
    for (int i = 0; i < 3; i++) res_ok(11);
    res_bad(12);
    fetch(11); chk(0, 0, "R6 window ignored with mode off");
    do_flush();
    dist_mode = 1'b1;
    res_bad(12);
    for (int i = 1; i <= 4; i++) begin
      fetch(11); chk(i, (i >= 2) ? 1 : 0, "R6 window classes low");
    end
    for (int i = 3; i >= 0; i--) begin
      res_ok(11); chk(i, (i >= 2) ? 1 : 0, "R6 window branches resolve");
    end
    fetch(11); chk(0, 0, "R6 window used up");
    do_flush();
    dist_mode = 1'b0;
  endtask

  task automatic t_same_cycle();
    do_flush();
    fetch(3); chk(1, 0, "R7 setup");
    step(1'b1, 4, 1'b1, 3, 1'b0, 1'b0); chk(1, 0, "R7 fetch and resolve together");
    res_ok(4); chk(0, 0, "R7 remaining tag was low");
  endtask

  task automatic t_underflow();
    do_flush();
    res_ok(14);  chk(0, 0, "R8 empty resolve");
    res_bad(14); chk(0, 0, "R8 empty mispredict");
  endtask

  task automatic t_full_thresh();
    do_flush();
    fetch(13); fetch(14); fetch(15); fetch(0);
    chk(4, 1, "R3 four low fetches");
    fetch(13); chk(4, 1, "R9 fetch into full queue dropped");
    gate_thresh = 3'd4; #1; check(int'(fetch_gate), 1, "R5 threshold 4");
    gate_thresh = 3'd5; #1; check(int'(fetch_gate), 0, "R5 threshold 5");
    gate_thresh = 3'd0; #1; check(int'(fetch_gate), 0, "R5 threshold 0 disables");
    gate_thresh = 3'd2; #1;
    res_ok(13); res_ok(14); res_ok(15); res_ok(0);
    chk(0, 0, "R4 queue drained");
    res_ok(13); chk(0, 0, "R9 dropped fetch left no tag");
  endtask

  task automatic t_flush();
    do_flush();
    fetch(0); fetch(0); chk(2, 1, "R10 setup");
    step(1'b1, 0, 1'b0, 0, 1'b0, 1'b1); chk(0, 0, "R10 flush beats fetch");
    res_ok(0); chk(0, 0, "R10 queue emptied");
  endtask

  task automatic t_saturate();
    do_flush();
    for (int i = 0; i < 16; i++) res_ok(6);
    fetch(6); chk(0, 0, "R11 saturated counter stays high");
    do_flush();
  endtask

  initial begin
    rst_n = 1'b0; flush = 1'b0; dist_mode = 1'b0; gate_thresh = 3'd2;
    fetch_vld = 1'b0; fetch_pc = '0; resolve_vld = 1'b0; resolve_pc = '0;
    resolve_miss = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_count_gate();
    t_training();
    t_alias();
    t_distance();
    t_same_cycle();
    t_underflow();
    t_full_thresh();
    t_flush();
    t_saturate();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule